// File: doc/BRIEF.md
# Transmitter Disable and Fault Latch Controller

This block decides when a laser transmitter may emit light. Two disable sources act together: an external pin and a bit the host writes. Either one keeps the transmitter dark. The pin is pulled high outside the block, so the transmitter stays off until the pin is driven low. Before the block uses the pin, it passes it through a synchronizer and a debounce filter.

A raw out-of-range pulse from the laser monitor sets a sticky fault. The fault forces the transmitter off and is reported both on a dedicated output and in a status byte. The host clears the fault in one of two ways. It can hold the disable pin asserted for at least a minimum reset time and then release it. It can also drop power-good.

Each clear starts a fresh initialization window. The transmitter stays off during that window, and fault pulses are ignored while it runs. If the fault is still present when the window ends, it latches again. All time limits are cycle-count parameters.

Top module: `txc_ctrl`

## Requirements
- R1: After reset, with the pin high and power-good high, `tx_en_o` is 0 and `fault_o` is 0. `status_o` reads 8'h81: bit 7 is 1 because the pin is asserted, and bit 0 is 1 because initialization is not done.
- R2: A pin level that lasts fewer than `FILT_CYCLES` synchronized cycles is ignored. Neither `tx_en_o` nor status bit 7 changes.
- R3: After a stable pin change, status bit 7 follows the pin after `SYNC_STAGES+FILT_CYCLES` clock edges. `tx_en_o` follows one edge later and goes low on a rise or high on a fall. A plain release with no fault latched does not restart initialization.
- R4: A write of 1 to the soft-disable bit (`soft_we_i` with `soft_val_i`=1) drives `tx_en_o` low on the second edge. A write of 0 lets it return high. The soft bit and the pin are ORed.
- R5: Once initialization is done, a one-cycle `fault_raw_i` pulse latches `fault_o`=1, sets status bit 2 and forces `tx_en_o` to 0. The fault stays latched after the pulse ends.
- R6: A filtered pin pulse shorter than `HOLD_CYCLES` does not clear a latched fault.
- R7: If the filtered pin is held high for at least `HOLD_CYCLES` and then falls while a fault is latched, the fault clears. Initialization restarts (status bit 0 = 1), and `tx_en_o` rises only after `INIT_CYCLES` more cycles.
- R8: If `fault_raw_i` is still high when the restarted initialization completes, the fault latches again.
- R9: `fault_raw_i` has no effect while initialization is running.
- R10: When `pwr_good_i` is low, the soft bit and the fault clear and initialization is held off. After power-good returns, `tx_en_o` stays 0 for `INIT_CYCLES` and then follows the disable sources.
- R11: The status byte has bit 7 = filtered pin, bit 2 = fault and bit 0 = not-ready (1 until initialization completes). All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_disable_i | input | 1 | Asynchronous disable pin, high disables |
| soft_we_i | input | 1 | Write strobe for the soft-disable bit |
| soft_val_i | input | 1 | Value written into the soft-disable bit |
| fault_raw_i | input | 1 | Raw laser out-of-range indication |
| pwr_good_i | input | 1 | Supply good; low acts as a power cycle |
| tx_en_o | output | 1 | Transmitter enable |
| fault_o | output | 1 | Latched fault, high means fault |
| status_o | output | 8 | Status byte (bits 7, 2, 0 used) |

## Verification
The hardest state to reach is a fault that persists across a clear. The pin must be held past the reset time and released while the fault is latched, and `fault_raw_i` must stay high through the whole restarted initialization window. The bench latches a fault and releases a long pin pulse. It keeps the raw fault high throughout and samples twice: once inside the window, to see that the fault is ignored, and once after the window, to see it latch again. A second pulse that passes the filter but is shorter than the hold time checks that a mere filtered edge is not enough to clear.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int unsigned STAT_W      = 8;
  localparam int unsigned STAT_HW_DIS = 7;
  localparam int unsigned STAT_FAULT  = 2;
  localparam int unsigned STAT_NRDY   = 0;
endpackage

// File: rtl/txc_pin_filter.sv
module txc_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES:0] sync_q;
  assign sync_q[0] = pin_i;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g+1] <= 1'b1;
      else         sync_q[g+1] <= sync_q[g];
    end
  end

  logic          pin_s, level_q, differ, update;
  logic [CW-1:0] cnt_q;

  assign pin_s  = sync_q[SYNC_STAGES];
  assign differ = pin_s != level_q;
  assign update = differ && (cnt_q == CW'(FILT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!differ) begin
      cnt_q   <= '0;
    end else if (update) begin
      level_q <= pin_s;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;
  assign fall_o  = update && level_q;

  a_r2_level_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !differ |=> $stable(level_q));
endmodule

// File: rtl/txc_fault_latch.sv
module txc_fault_latch #(
  parameter int unsigned HOLD_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_i,
  input  logic init_done_i,
  input  logic fault_raw_i,
  input  logic level_i,
  input  logic fall_i,
  output logic fault_o,
  output logic restart_o
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] hold_q;
  logic          hold_ok, fault_q;

  assign hold_ok   = hold_q >= HW'(HOLD_CYCLES);
  assign restart_o = pg_i && fall_i && hold_ok && fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= '0;
    else if (!pg_i || !level_i)  hold_q <= '0;
    else if (!hold_ok)           hold_q <= hold_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           fault_q <= 1'b0;
    else if (!pg_i)                        fault_q <= 1'b0;
    else if (restart_o)                    fault_q <= 1'b0;
    else if (fault_raw_i && init_done_i)   fault_q <= 1'b1;
  end

  assign fault_o = fault_q;

  a_r5_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q && pg_i && !restart_o |=> fault_q);
  a_r6_clear_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q && fall_i && !hold_ok && pg_i |=> fault_q);
  a_r9_no_set_in_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_q && !init_done_i |=> !fault_q);
endmodule

// File: rtl/txc_init_timer.sv
module txc_init_timer #(
  parameter int unsigned INIT_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_i,
  input  logic restart_i,
  output logic done_o
);
  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);

  logic [IW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!pg_i || restart_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == IW'(INIT_CYCLES - 1)) done_q <= 1'b1;
      else                               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  a_r7_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o);
  a_r10_pg_holds_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_i |=> !done_o);
endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl
  import txc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 4,
  parameter int unsigned HOLD_CYCLES = 12,
  parameter int unsigned INIT_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_disable_i,
  input  logic              soft_we_i,
  input  logic              soft_val_i,
  input  logic              fault_raw_i,
  input  logic              pwr_good_i,
  output logic              tx_en_o,
  output logic              fault_o,
  output logic [STAT_W-1:0] status_o
);
  logic hw_dis, hw_fall, fault, restart, init_done, soft_q, tx_en_q;

  txc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) i_filter (
    .clk_i, .rst_ni, .pin_i(pin_disable_i), .level_o(hw_dis), .fall_o(hw_fall)
  );

  txc_fault_latch #(.HOLD_CYCLES(HOLD_CYCLES)) i_fault (
    .clk_i, .rst_ni, .pg_i(pwr_good_i), .init_done_i(init_done),
    .fault_raw_i, .level_i(hw_dis), .fall_i(hw_fall),
    .fault_o(fault), .restart_o(restart)
  );

  txc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) i_init (
    .clk_i, .rst_ni, .pg_i(pwr_good_i), .restart_i(restart), .done_o(init_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         soft_q <= 1'b0;
    else if (!pwr_good_i) soft_q <= 1'b0;
    else if (soft_we_i)  soft_q <= soft_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_en_q <= 1'b0;
    else         tx_en_q <= pwr_good_i && init_done && !hw_dis && !soft_q && !fault;
  end

  always_comb begin
    status_o              = '0;
    status_o[STAT_HW_DIS] = hw_dis;
    status_o[STAT_FAULT]  = fault;
    status_o[STAT_NRDY]   = !init_done;
  end

  assign tx_en_o = tx_en_q;
  assign fault_o = fault;

  a_r3_pin_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_dis |=> !tx_en_o);
  a_r4_soft_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_q |=> !tx_en_o);
  a_r5_fault_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !tx_en_o);
  a_r10_pg_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !soft_q && !fault_o && !tx_en_o);
endmodule

// File: tb/test_txc_ctrl.sv
module test_txc_ctrl;
  localparam int SYNC = 2, FILT = 4, HOLD = 12, INIT = 20;
  localparam int LAT  = SYNC + FILT + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b1, soft_we = 1'b0, soft_val = 1'b0, fraw = 1'b0, pg = 1'b1;
  logic       tx_en, fault;
  logic [7:0] status;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  txc_ctrl #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD),
             .INIT_CYCLES(INIT)) i_txc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_disable_i(pin), .soft_we_i(soft_we),
    .soft_val_i(soft_val), .fault_raw_i(fraw), .pwr_good_i(pg),
    .tx_en_o(tx_en), .fault_o(fault), .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(3); rst_n = 1'b1;
    chk(tx_en == 0, "R1 tx_en", tx_en, 0);
    chk(fault == 0, "R1 fault", fault, 0);
    chk(status == 8'h81, "R1/R11 status", status, 8'h81);
    pin = 1'b0;
    cyc(INIT + LAT + 5);
    chk(tx_en == 1, "R3 enabled after init", tx_en, 1);
    chk(status == 8'h00, "R11 status ready", status, 0);
  endtask

  task automatic t_glitch;
    bit seen_off = 0;
    pin = 1'b1; cyc(FILT - 1); pin = 1'b0;
    for (int i = 0; i < 12; i++) begin
      cyc(1);
      if (!tx_en || status[7]) seen_off = 1;
    end
    chk(!seen_off, "R2 short glitch ignored", seen_off, 0);
  endtask

  task automatic t_latency;
    pin = 1'b1; cyc(LAT - 1);
    chk(tx_en == 1, "R3 still on before limit", tx_en, 1);
    chk(status[7] == 1, "R3 status bit7 follows", status[7], 1);
    cyc(1);
    chk(tx_en == 0, "R3 off at limit", tx_en, 0);
    cyc(5); pin = 1'b0; cyc(LAT - 1);
    chk(tx_en == 0, "R3 still off before limit", tx_en, 0);
    cyc(1);
    chk(tx_en == 1, "R3 on at limit, no init restart", tx_en, 1);
  endtask

  task automatic t_soft;
    soft_we = 1'b1; soft_val = 1'b1; cyc(1); soft_we = 1'b0; cyc(1);
    chk(tx_en == 0, "R4 soft disable", tx_en, 0);
    soft_we = 1'b1; soft_val = 1'b0; cyc(1); soft_we = 1'b0; cyc(2);
    chk(tx_en == 1, "R4 soft enable", tx_en, 1);
  endtask

  task automatic t_fault;
    fraw = 1'b1; cyc(1); fraw = 1'b0; cyc(2);
    chk(fault == 1, "R5 fault latched", fault, 1);
    chk(tx_en == 0, "R5 tx off", tx_en, 0);
    chk(status == 8'h04, "R5/R11 status", status, 8'h04);
    cyc(20);
    chk(fault == 1, "R5 fault sticky", fault, 1);
  endtask

  task automatic t_short_pulse;
    pin = 1'b1; cyc(6); pin = 1'b0; cyc(20);
    chk(fault == 1, "R6 short pulse keeps fault", fault, 1);
    chk(tx_en == 0, "R6 tx stays off", tx_en, 0);
  endtask

  task automatic t_clear;
    pin = 1'b1; cyc(30); pin = 1'b0; cyc(LAT + 2);
    chk(fault == 0, "R7 fault cleared", fault, 0);
    chk(status == 8'h01, "R7 init restarted", status, 8'h01);
    chk(tx_en == 0, "R7 off during init", tx_en, 0);
    cyc(INIT + 5);
    chk(tx_en == 1, "R7 on after init", tx_en, 1);
  endtask

  task automatic t_persist;
    fraw = 1'b1; cyc(3);
    chk(fault == 1, "R8 setup latch", fault, 1);
    pin = 1'b1; cyc(30); pin = 1'b0; cyc(LAT + 2);
    chk(fault == 0, "R9 cleared despite raw high", fault, 0);
    cyc(10);
    chk(fault == 0, "R9 raw ignored during init", fault, 0);
    cyc(INIT + 5);
    chk(fault == 1, "R8 re-latched after init", fault, 1);
    fraw = 1'b0;
  endtask

  task automatic t_power;
    soft_we = 1'b1; soft_val = 1'b1; cyc(1); soft_we = 1'b0;
    pg = 1'b0; cyc(3);
    chk(fault == 0, "R10 fault cleared by power", fault, 0);
    chk(status == 8'h01, "R10 status during power loss", status, 8'h01);
    pg = 1'b1; cyc(3);
    chk(tx_en == 0, "R10 off while init reruns", tx_en, 0);
    cyc(INIT + 5);
    chk(tx_en == 1, "R10 soft bit cleared", tx_en, 1);
    chk(status == 8'h00, "R11 status after power", status, 0);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_latency();
    t_soft();
    t_fault();
    t_short_pulse();
    t_clear();
    t_persist();
    t_power();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule